// File: doc/BRIEF.md
# Programmable Delayed Frame-Sync Generator

This block derives several frame-sync strobes from one reference frame sync on a time-division serial port. Each strobe is placed a programmed number of data-clock cycles after the reference. Every channel keeps its own 16-bit delay register. When the block sees a rising edge on the reference, every channel starts counting down its own delay. When the count runs out, the channel drives a one-cycle pulse on its output. All channels are timed from that same reference edge and never from one another.

The main use is to stack several codecs on one shared data line. In a 10-bit frame, the second slot of a device pair starts 10 clocks after the first. Delays of 20 and 40 therefore move the second and third pairs into the next free slot pairs. The delays are loaded through a plain synchronous write port (enable, channel index, value). A new value does not change a count already running; it is used from the next reference edge on. The whole block runs on the data clock and has a synchronous active-high reset.

The block carries no data stream, so it has no valid/ready handshake. The write port is a control input that takes effect in the cycle it is driven and never pushes back.

Top module: `fsync_delay_gen`

## Requirements
- R1: Let a reference rising edge be seen in cycle t: `fs_ref` is high in cycle t and was low in cycle t-1. A channel whose delay register holds D > 0 then drives its `fs_out` bit high in cycle t+D (for example, 0x0014 gives cycle t+20 and 0x0028 gives cycle t+40).
- R2: Each reference edge gives at most one pulse per channel, and that pulse is exactly one cycle wide.
- R3: A channel with delay 0 drives its pulse in cycle t itself, the same cycle as the reference edge.
- R4: Every channel is timed only from the shared reference edge. The delays and pulses of one channel do not affect any other channel.
- R5: In a cycle with `cfg_we` high, `cfg_wdata` is stored into the delay register of channel `cfg_addr`. A write to an index of NUM_CH or above changes no register.
- R6: A delay written while a channel is counting does not change the pulse of that count. The next reference edge uses the new value. A write in the same cycle as an edge also takes effect only from the following edge.
- R7: A reference edge that arrives before a channel's count has run out restarts the count from the new edge, and the pulse of the old count is dropped.
- R8: If a count runs out in the same cycle as a new reference edge, the old pulse is still emitted in that cycle and the count restarts from the new edge.
- R9: While `rst` is high, all outputs are low. Reset clears the counters, the edge detector and the delay registers to 0.
- R10: A reference held high for several cycles counts as a single edge, in its first high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fs_ref | input | 1 | Reference frame sync, level sampled every cycle |
| cfg_we | input | 1 | Delay register write enable |
| cfg_addr | input | ADDR_W (2) | Channel index for the write |
| cfg_wdata | input | DLY_W (16) | Delay value in data-clock cycles |
| fs_out | output | NUM_CH (3) | Delayed frame-sync pulses, bit k for channel k |

## Verification
Two functions can fall in the same cycle, and the bench provokes both on purpose. The first is a channel's count running out while a new reference edge arrives. The bench spaces two reference pulses exactly one delay apart. It then judges that the expiring pulse still appears and that the next pulse comes one full delay after the second edge. The second is a register write in the same cycle as a reference edge, or while a count is running. The bench judges that the current count keeps its old delay and that the following frame uses the new one. A behavioural model of counters and registers is compared with every output bit on every cycle.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fsd_edge.sv
module fsd_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign rise = level & ~level_q & ~rst;

  // a held-high reference yields one edge only
  p_single_edge_r10: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/fsd_regs.sv
module fsd_regs #(
  parameter int NUM_CH = 3,
  parameter int DLY_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DLY_W-1:0]               wdata,
  output logic [NUM_CH-1:0][DLY_W-1:0]   dly
);
  logic addr_ok;
  assign addr_ok = (int'(addr) < NUM_CH);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_reg
    logic hit;
    assign hit = we && addr_ok && (int'(addr) == k);

    always_ff @(posedge clk) begin
      if (rst)      dly[k] <= '0;
      else if (hit) dly[k] <= wdata;
    end

    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
      (we && int'(addr) == k) |=> dly[k] == $past(wdata));
  end

  p_bad_index_r5: assert property (@(posedge clk) disable iff (rst)
    (we && !addr_ok) |=> $stable(dly));
endmodule

// File: rtl/fsd_chan.sv
module fsd_chan #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic [DLY_W-1:0] dly,
  output logic             fs
);
  logic [DLY_W-1:0] cnt;
  logic             busy;
  logic             expire;
  logic             zero_now;

  assign expire   = busy && (cnt == DLY_W'(1));
  assign zero_now = rise && (dly == '0);
  assign fs       = ~rst & (expire | zero_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (rise) begin
      cnt  <= dly;
      busy <= (dly != '0);
    end else if (busy) begin
      if (expire) busy <= 1'b0;
      else        cnt  <= cnt - DLY_W'(1);
    end
  end

  // count latched at the edge, later writes do not touch it
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    (rise && dly != '0) |=> (busy && cnt == $past(dly)));

  p_countdown_r1: assert property (@(posedge clk) disable iff (rst)
    (busy && !rise && cnt != DLY_W'(1)) |=> (busy && cnt == $past(cnt) - DLY_W'(1)));

  p_one_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (expire && !rise) |=> !busy);

  p_no_stray_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !rise) |-> !fs);
endmodule

// File: rtl/fsync_delay_gen.sv
module fsync_delay_gen #(
  parameter int NUM_CH = 3,
  parameter int DLY_W  = 16,
  parameter int ADDR_W = fsd_pkg::idx_bits(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs_ref,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DLY_W-1:0]  cfg_wdata,
  output logic [NUM_CH-1:0] fs_out
);
  logic                         ref_rise;
  logic [NUM_CH-1:0][DLY_W-1:0] dly;

  fsd_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (fs_ref),
    .rise  (ref_rise)
  );

  fsd_regs #(.NUM_CH(NUM_CH), .DLY_W(DLY_W), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .dly   (dly)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    fsd_chan #(.DLY_W(DLY_W)) u_chan (
      .clk  (clk),
      .rst  (rst),
      .rise (ref_rise),
      .dly  (dly[k]),
      .fs   (fs_out[k])
    );
  end
endmodule

// File: tb/fsync_delay_gen_tb.sv
module fsync_delay_gen_tb;
  localparam int NCH = 3;
  localparam int DW  = 16;
  localparam int AW  = 2;

  logic          clk = 1'b0;
  logic          rst, fs_ref, cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_wdata;
  logic [NCH-1:0] fs_out;

  always #10 clk = ~clk;

  fsync_delay_gen #(.NUM_CH(NCH), .DLY_W(DW)) u_dut (
    .clk(clk), .rst(rst), .fs_ref(fs_ref), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .fs_out(fs_out)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string tag = "R9";
  int m_reg [NCH];
  int m_rem [NCH];
  bit m_refq;
  int last_hi [NCH];
  int rise_cyc;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare before posedge, advance model
  task automatic step(bit r, bit rf, bit we, int a, int d);
    bit rise;
    @(negedge clk);
    rst = r; fs_ref = rf; cfg_we = we; cfg_addr = AW'(a); cfg_wdata = DW'(d);
    #8;
    rise = rf && !m_refq && !r;
    if (rise) rise_cyc = cyc;
    for (int k = 0; k < NCH; k++) begin
      bit e;
      e = !r && ((m_rem[k] == 1) || (rise && m_reg[k] == 0));
      check(tag, int'(fs_out[k]), int'(e));
      if (fs_out[k]) last_hi[k] = cyc;
    end
    if (r) begin
      for (int k = 0; k < NCH; k++) begin m_reg[k] = 0; m_rem[k] = 0; end
      m_refq = 0;
    end else begin
      for (int k = 0; k < NCH; k++) begin
        if (rise) m_rem[k] = m_reg[k];
        else if (m_rem[k] > 0) m_rem[k]--;
      end
      if (we && a < NCH) m_reg[a] = d;
      m_refq = rf;
    end
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic wr(int a, int d);
    step(0, 0, 1, a, d);
  endtask

  task automatic pulse();
    step(0, 1, 0, 0, 0);
  endtask

  initial begin
    rst = 1; fs_ref = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    m_refq = 0;
    for (int k = 0; k < NCH; k++) begin m_reg[k] = 0; m_rem[k] = 0; last_hi[k] = -1; end
    // R9: reset holds outputs low even with reference activity
    tag = "R9";
    step(1, 1, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 1, 0, 0, 0); step(1, 0, 0, 0, 0);
    // R5: program slots, plus a write to a missing index
    tag = "R5";
    wr(0, 0); wr(1, 'h14); wr(2, 'h28); wr(3, 5);
    idle(2);
    // R1 R3 R4: one frame, slot offsets from one reference
    tag = "R1";
    pulse();
    idle(60);
    check("R1", last_hi[1] - rise_cyc, 20);
    check("R1", last_hi[2] - rise_cyc, 40);
    check("R3", last_hi[0] - rise_cyc, 0);
    // R10: held-high reference is one edge
    tag = "R10";
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0);
    idle(50);
    check("R10", last_hi[1] - rise_cyc, 20);
    // R6: write during a count, and write in the edge cycle
    tag = "R6";
    step(0, 1, 1, 2, 9);
    idle(5);
    wr(1, 7);
    idle(45);
    check("R6", last_hi[2] - rise_cyc, 40);
    pulse();
    idle(25);
    check("R6", last_hi[1] - rise_cyc, 7);
    check("R6", last_hi[2] - rise_cyc, 9);
    // R7: new edge before expiry restarts the count
    tag = "R7";
    wr(2, 30); idle(2);
    pulse(); idle(14);
    pulse(); idle(40);
    check("R7", last_hi[2] - rise_cyc, 30);
    // R8: expiry and new edge in the same cycle (ch1 delay 7)
    tag = "R8";
    pulse(); idle(6);
    pulse();
    check("R8", last_hi[1], rise_cyc);
    idle(10);
    check("R8", last_hi[1] - rise_cyc, 7);
    // R4: channel 0 nonzero, others unaffected
    tag = "R4";
    wr(0, 3); wr(1, 1); idle(1);
    pulse(); idle(35);
    check("R4", last_hi[0] - rise_cyc, 3);
    check("R4", last_hi[1] - rise_cyc, 1);
    // R9: reset in mid count drops the pulse
    tag = "R9";
    pulse(); idle(4);
    step(1, 0, 0, 0, 0);
    idle(40);
    tag = "R2";
    wr(1, 2); wr(2, 2); idle(1);
    pulse(); idle(8);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule